// File: doc/BRIEF.md
# Prioritized Trap Interrupt Arbiter

This block keeps the pending interrupts of one processor thread and decides which of them is delivered next. Seven interrupt classes are tracked, each with a 64-bit pending vector. Single bits are set through a post port and removed through a clear port; each port names a class code and a bit index. A summary word holds one bit per class that shows whether the class has anything pending. Any class vector can be read back by its code.

The winner depends on two mode inputs: the hypervisor-privilege flag and the interrupt-enable flag. With hypervisor privilege, only two classes compete. Without it, three classes are delivered whatever the enable flag says, and four more are delivered only when interrupts are enabled. The chosen class appears as a binary code and as a one-hot word, with a valid flag. A separate output reduces the software-interrupt vector to a level number.

The outputs are combinational from the registered pending state. An update made at a clock edge is therefore visible on the outputs for the whole following cycle.

Top module: `irq_trap_arbiter`

## Requirements
- R1: After reset every pending vector and every summary bit is zero, `take_valid` is 0 and `soft_level` is 0.
- R2: Class codes are 0 trap-level-zero, 1 tick-match, 2 interrupt-vector, 3 cpu-mailbox, 4 device-mailbox, 5 software, 6 resumable-error. A post sets bit `post_idx` of the vector of class `post_type`, and it sets bit `post_type` of `status`.
- R3: A clear resets bit `clr_idx` of the vector of class `clr_type`. The summary bit of that class drops only once the whole vector is zero.
- R4: When a post and a clear hit the same class and index in one cycle, the bit ends up set.
- R5: Class code 7 is ignored by post and by clear. A read-back with `rd_type` = 7 returns zero.
- R6: With `hpriv`=1, only class 1 and then class 2 can be delivered, whatever `int_en` is.
- R7: With `hpriv`=0, classes 0, 1 and 2 are delivered in that priority order, whatever `int_en` is.
- R8: With `hpriv`=0 and `int_en`=1, classes 3, 4, 5 and 6 follow, in that order. With `int_en`=0 they are never delivered.
- R9: `take_code` carries the winning class code and `take_onehot` has only that bit set. `take_valid` is 1 exactly when some class is eligible. All three follow the state in the cycle after an update.
- R10: If bit 0 or bit 16 of the software vector is set, `soft_level` is 14.
- R11: Otherwise `soft_level` is the highest set bit among bits 14 down to 1 of the software vector, or 0 if none of them is set. Bit 15 and the bits above 16 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_en | input | 1 | Post strobe |
| post_type | input | 3 | Class code for the post |
| post_idx | input | 6 | Bit index for the post |
| clr_en | input | 1 | Clear strobe |
| clr_type | input | 3 | Class code for the clear |
| clr_idx | input | 6 | Bit index for the clear |
| hpriv | input | 1 | Hypervisor-privilege mode |
| int_en | input | 1 | Interrupt enable |
| rd_type | input | 3 | Class code for read-back |
| rd_vec | output | 64 | Pending vector of class `rd_type` |
| status | output | 7 | Per-class summary bits |
| take_valid | output | 1 | An interrupt is eligible |
| take_onehot | output | 7 | Winning class, one-hot |
| take_code | output | 3 | Winning class, binary |
| soft_level | output | 4 | Software interrupt level |

## Verification
The bench clears a vector bit by bit and checks that the summary bit stays set until the last bit is gone. A design that tracked only the most recent clear would drop the summary early. It runs a post and a clear on the same bit in the same cycle; a design that let the clear win would lose the interrupt. It walks the full priority ladder with the enable flag both low and high, and repeats this in hypervisor mode. Getting this wrong would let a mailbox or software interrupt through while masked, or let trap-level-zero through in hypervisor mode. The software level is driven with bit 15, with bit 16 alone and with bit 0 mixed with lower bits, which catches a scan that includes bit 15 or a design that ignores the forcing bits.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int IRQ_NT = 7;
   localparam int IRQ_TW = 3;

   typedef enum logic [IRQ_TW-1:0] {
      IRQ_TLZ    = 3'd0,
      IRQ_HTICK  = 3'd1,
      IRQ_IVEC   = 3'd2,
      IRQ_CPUMB  = 3'd3,
      IRQ_DEVMB  = 3'd4,
      IRQ_SOFT   = 3'd5,
      IRQ_RESERR = 3'd6
   } irq_type_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int NT    = 7,
   parameter int VEC_W = 64,
   parameter int TW    = 3,
   parameter int IW    = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      post_en,
   input  logic [TW-1:0]             post_type,
   input  logic [IW-1:0]             post_idx,
   input  logic                      clr_en,
   input  logic [TW-1:0]             clr_type,
   input  logic [IW-1:0]             clr_idx,
   output logic [NT-1:0][VEC_W-1:0]  pend_q,
   output logic [NT-1:0]             status_q
);
   for (genvar t = 0; t < NT; t++) begin : g_type
      logic             hit_post;
      logic             hit_clr;
      logic [VEC_W-1:0] set_mask;
      logic [VEC_W-1:0] kill_mask;
      logic [VEC_W-1:0] vec_nxt;
      logic [VEC_W-1:0] vec_r;
      logic             sum_r;

      assign hit_post  = post_en && (post_type == TW'(t));
      assign hit_clr   = clr_en && (clr_type == TW'(t));
      assign set_mask  = hit_post ? (VEC_W'(1) << post_idx) : '0;
      assign kill_mask = hit_clr ? (VEC_W'(1) << clr_idx) : '0;
      // the set mask is applied last, so a post beats a clear on the same bit
      assign vec_nxt   = (vec_r & ~kill_mask) | set_mask;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vec_r <= '0;
            sum_r <= 1'b0;
         end else begin
            vec_r <= vec_nxt;
            if (hit_post)
               sum_r <= 1'b1;
            else if (hit_clr && (vec_nxt == '0))
               sum_r <= 1'b0;
         end
      end

      assign pend_q[t]   = vec_r;
      assign status_q[t] = sum_r;
   end
endmodule

// File: rtl/irq_soft_level.sv
module irq_soft_level #(
   parameter int VEC_W    = 64,
   parameter int TOP      = 14,
   parameter int FORCE_HI = 16,
   parameter int LW       = 4
) (
   input  logic [VEC_W-1:0] soft_vec,
   output logic [LW-1:0]    level
);
   logic [LW-1:0] scan_lvl;
   logic          forced;

   always_comb begin
      scan_lvl = '0;
      for (int b = 1; b <= TOP; b++) begin
         if (soft_vec[b]) scan_lvl = LW'(b);
      end
   end

   assign forced = soft_vec[0] | soft_vec[FORCE_HI];
   assign level  = forced ? LW'(TOP) : scan_lvl;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
   import irq_arb_pkg::*;
#(
   parameter int NT = 7,
   parameter int TW = 3
) (
   input  logic [NT-1:0] status_q,
   input  logic          hpriv,
   input  logic          int_en,
   output logic          take_valid,
   output logic [NT-1:0] take_onehot,
   output logic [TW-1:0] take_code
);
   logic [NT-1:0] allowed;
   logic [NT-1:0] elig;

   always_comb begin
      allowed             = '0;
      allowed[IRQ_TLZ]    = !hpriv;
      allowed[IRQ_HTICK]  = 1'b1;
      allowed[IRQ_IVEC]   = 1'b1;
      allowed[IRQ_CPUMB]  = !hpriv && int_en;
      allowed[IRQ_DEVMB]  = !hpriv && int_en;
      allowed[IRQ_SOFT]   = !hpriv && int_en;
      allowed[IRQ_RESERR] = !hpriv && int_en;
   end

   assign elig = status_q & allowed;

   // class codes are numbered in priority order: lowest code wins
   always_comb begin
      take_code = '0;
      for (int t = NT - 1; t >= 0; t--) begin
         if (elig[t]) take_code = TW'(t);
      end
   end

   assign take_valid  = |elig;
   assign take_onehot = take_valid ? (NT'(1) << take_code) : '0;
endmodule

// File: rtl/irq_trap_arbiter.sv
module irq_trap_arbiter
   import irq_arb_pkg::*;
#(
   parameter int VEC_W    = 64,
   parameter int SOFT_TOP = 14,
   parameter int SOFT_HI  = 16,
   localparam int NT      = IRQ_NT,
   localparam int TW      = IRQ_TW,
   localparam int IW      = $clog2(VEC_W),
   localparam int LW      = $clog2(SOFT_TOP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             post_en,
   input  logic [TW-1:0]    post_type,
   input  logic [IW-1:0]    post_idx,
   input  logic             clr_en,
   input  logic [TW-1:0]    clr_type,
   input  logic [IW-1:0]    clr_idx,
   input  logic             hpriv,
   input  logic             int_en,
   input  logic [TW-1:0]    rd_type,
   output logic [VEC_W-1:0] rd_vec,
   output logic [NT-1:0]    status,
   output logic             take_valid,
   output logic [NT-1:0]    take_onehot,
   output logic [TW-1:0]    take_code,
   output logic [LW-1:0]    soft_level
);
   if (SOFT_HI >= VEC_W) begin : g_bad_hi
      $error("SOFT_HI must index a bit of the vector");
   end
   if (SOFT_TOP >= SOFT_HI || SOFT_TOP < 1) begin : g_bad_top
      $error("SOFT_TOP must lie between 1 and SOFT_HI-1");
   end
   if ((1 << TW) < NT) begin : g_bad_tw
      $error("class code too narrow");
   end

   logic [NT-1:0][VEC_W-1:0] pend_q;
   logic [NT-1:0]            status_q;
   logic [VEC_W-1:0]         soft_vec;

   irq_pend_bank #(.NT(NT), .VEC_W(VEC_W), .TW(TW), .IW(IW)) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .post_en  (post_en),
      .post_type(post_type),
      .post_idx (post_idx),
      .clr_en   (clr_en),
      .clr_type (clr_type),
      .clr_idx  (clr_idx),
      .pend_q   (pend_q),
      .status_q (status_q)
   );

   assign soft_vec = pend_q[IRQ_SOFT];

   irq_soft_level #(.VEC_W(VEC_W), .TOP(SOFT_TOP), .FORCE_HI(SOFT_HI), .LW(LW)) i_lvl (
      .soft_vec(soft_vec),
      .level   (soft_level)
   );

   irq_prio_sel #(.NT(NT), .TW(TW)) i_sel (
      .status_q   (status_q),
      .hpriv      (hpriv),
      .int_en     (int_en),
      .take_valid (take_valid),
      .take_onehot(take_onehot),
      .take_code  (take_code)
   );

   always_comb begin
      rd_vec = '0;
      for (int t = 0; t < NT; t++) begin
         if (rd_type == TW'(t)) rd_vec = pend_q[t];
      end
   end

   assign status = status_q;
endmodule

// File: rtl/irq_trap_arbiter_chk.sv
module irq_trap_arbiter_chk #(
   parameter int NT       = 7,
   parameter int TW       = 3,
   parameter int VEC_W    = 64,
   parameter int SOFT_TOP = 14,
   parameter int SOFT_HI  = 16,
   parameter int LW       = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     post_en,
   input logic [TW-1:0]            post_type,
   input logic                     hpriv,
   input logic                     int_en,
   input logic                     take_valid,
   input logic [NT-1:0]            take_onehot,
   input logic [TW-1:0]            take_code,
   input logic [NT-1:0]            status_q,
   input logic [NT-1:0][VEC_W-1:0] pend_q,
   input logic [LW-1:0]            soft_level
);
   for (genvar t = 0; t < NT; t++) begin : g_sum
      p_summary_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
         status_q[t] == (|pend_q[t]));
   end

   p_post_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (post_en && post_type < TW'(NT)) |=> status_q[$past(post_type)]);

   p_priv_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hpriv && take_valid) |-> (take_code == TW'(1) || take_code == TW'(2)));

   p_tlz_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!hpriv && status_q[0]) |-> (take_valid && take_code == TW'(0)));

   p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !int_en |-> !(take_valid && take_code >= TW'(3)));

   p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take_onehot) && (take_valid == (|take_onehot)));

   p_soft_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[5][0] || pend_q[5][SOFT_HI]) |-> (soft_level == LW'(SOFT_TOP)));
endmodule

bind irq_trap_arbiter irq_trap_arbiter_chk #(
   .NT(NT), .TW(TW), .VEC_W(VEC_W), .SOFT_TOP(SOFT_TOP), .SOFT_HI(SOFT_HI), .LW(LW)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .post_en    (post_en),
   .post_type  (post_type),
   .hpriv      (hpriv),
   .int_en     (int_en),
   .take_valid (take_valid),
   .take_onehot(take_onehot),
   .take_code  (take_code),
   .status_q   (status_q),
   .pend_q     (pend_q),
   .soft_level (soft_level)
);

// File: tb/test_irq_trap_arbiter.sv
module test_irq_trap_arbiter;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        post_en = 1'b0;
   logic [2:0]  post_type = '0;
   logic [5:0]  post_idx = '0;
   logic        clr_en = 1'b0;
   logic [2:0]  clr_type = '0;
   logic [5:0]  clr_idx = '0;
   logic        hpriv = 1'b0;
   logic        int_en = 1'b0;
   logic [2:0]  rd_type = '0;
   logic [63:0] rd_vec;
   logic [6:0]  status;
   logic        take_valid;
   logic [6:0]  take_onehot;
   logic [2:0]  take_code;
   logic [3:0]  soft_level;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   irq_trap_arbiter i_irq_trap_arbiter (
      .clk(clk), .rst_n(rst_n),
      .post_en(post_en), .post_type(post_type), .post_idx(post_idx),
      .clr_en(clr_en), .clr_type(clr_type), .clr_idx(clr_idx),
      .hpriv(hpriv), .int_en(int_en), .rd_type(rd_type),
      .rd_vec(rd_vec), .status(status), .take_valid(take_valid),
      .take_onehot(take_onehot), .take_code(take_code), .soft_level(soft_level)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; hpriv = 1'b0; int_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic op(input bit p, input int pt, input int pi, input bit c, input int ct, input int ci);
      @(negedge clk);
      post_en = p; post_type = 3'(pt); post_idx = 6'(pi);
      clr_en = c; clr_type = 3'(ct); clr_idx = 6'(ci);
      @(negedge clk);
      post_en = 1'b0; clr_en = 1'b0;
   endtask

   task automatic post(input int t, input int i);
      op(1'b1, t, i, 1'b0, 0, 0);
   endtask

   task automatic clear(input int t, input int i);
      op(1'b0, 0, 0, 1'b1, t, i);
   endtask

   task automatic expect_take(input bit v, input int code, input string req);
      #1;
      chk(take_valid == v, req, 64'(take_valid), 64'(v));
      if (v) begin
         chk(take_code == 3'(code), req, 64'(take_code), 64'(code));
         chk(take_onehot == 7'(1 << code), req, 64'(take_onehot), 64'(1 << code));
      end else begin
         chk(take_onehot == '0, req, 64'(take_onehot), 64'h0);
      end
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      chk(status == '0, "R1", 64'(status), 0);
      chk(soft_level == '0, "R1", 64'(soft_level), 0);
      for (int t = 0; t < 7; t++) begin
         rd_type = 3'(t); #1;
         chk(rd_vec == '0, "R1", rd_vec, 0);
      end
      expect_take(1'b0, 0, "R1");
   endtask

   task automatic t_post_clear();
      do_reset();
      post(3, 5);
      post(3, 63);
      rd_type = 3'd3; #1;
      chk(rd_vec == ((64'd1 << 5) | (64'd1 << 63)), "R2", rd_vec, (64'd1 << 5) | (64'd1 << 63));
      chk(status == 7'b0001000, "R2", 64'(status), 64'h8);
      clear(3, 5); #1;
      chk(rd_vec == (64'd1 << 63), "R3", rd_vec, 64'd1 << 63);
      chk(status[3] == 1'b1, "R3 summary kept", 64'(status), 64'h8);
      clear(3, 63); #1;
      chk(rd_vec == '0, "R3", rd_vec, 0);
      chk(status == '0, "R3 summary dropped", 64'(status), 0);
   endtask

   task automatic t_same_cycle();
      do_reset();
      op(1'b1, 6, 9, 1'b1, 6, 9);
      rd_type = 3'd6; #1;
      chk(rd_vec == (64'd1 << 9), "R4", rd_vec, 64'd1 << 9);
      chk(status == 7'b1000000, "R4", 64'(status), 64'h40);
   endtask

   task automatic t_bad_type();
      do_reset();
      post(7, 3);
      #1;
      chk(status == '0, "R5 post", 64'(status), 0);
      rd_type = 3'd7; #1;
      chk(rd_vec == '0, "R5 read", rd_vec, 0);
      post(2, 3);
      clear(7, 3);
      rd_type = 3'd2; #1;
      chk(rd_vec == (64'd1 << 3), "R5 clear", rd_vec, 64'd1 << 3);
   endtask

   task automatic t_hpriv();
      do_reset();
      post(0, 0); post(3, 1); post(5, 4); post(6, 2);
      @(negedge clk); hpriv = 1'b1; int_en = 1'b1;
      expect_take(1'b0, 0, "R6 none eligible");
      post(2, 7);
      expect_take(1'b1, 2, "R6 ivec");
      post(1, 0);
      expect_take(1'b1, 1, "R6 tick first");
      clear(1, 0);
      expect_take(1'b1, 2, "R6 back to ivec");
      int_en = 1'b0;
      expect_take(1'b1, 2, "R6 enable ignored");
   endtask

   task automatic t_ladder();
      do_reset();
      for (int t = 0; t < 7; t++) post(t, t + 10);
      hpriv = 1'b0; int_en = 1'b0;
      expect_take(1'b1, 0, "R7 tlz");
      clear(0, 10);
      expect_take(1'b1, 1, "R7 tick");
      clear(1, 11);
      expect_take(1'b1, 2, "R7 ivec");
      clear(2, 12);
      expect_take(1'b0, 0, "R8 masked");
      int_en = 1'b1;
      expect_take(1'b1, 3, "R8 cpu mailbox");
      clear(3, 13);
      expect_take(1'b1, 4, "R8 dev mailbox");
      clear(4, 14);
      expect_take(1'b1, 5, "R8 soft");
      clear(5, 15);
      expect_take(1'b1, 6, "R8 reserr");
      int_en = 1'b0;
      expect_take(1'b0, 0, "R9 valid low");
   endtask

   task automatic t_soft();
      do_reset();
      #1; chk(soft_level == 4'd0, "R11 empty", 64'(soft_level), 0);
      post(5, 15); #1;
      chk(soft_level == 4'd0, "R11 bit15 ignored", 64'(soft_level), 0);
      post(5, 3); post(5, 9); #1;
      chk(soft_level == 4'd9, "R11 highest", 64'(soft_level), 9);
      post(5, 14); #1;
      chk(soft_level == 4'd14, "R11 top", 64'(soft_level), 14);
      clear(5, 14); clear(5, 9); clear(5, 3); post(5, 1); #1;
      chk(soft_level == 4'd1, "R11 low", 64'(soft_level), 1);
      post(5, 0); #1;
      chk(soft_level == 4'd14, "R10 bit0", 64'(soft_level), 14);
      do_reset();
      post(5, 16); #1;
      chk(soft_level == 4'd14, "R10 bit16", 64'(soft_level), 14);
      post(5, 40); clear(5, 16); #1;
      chk(soft_level == 4'd0, "R11 high bits ignored", 64'(soft_level), 0);
   endtask

   initial begin
      t_reset();
      t_post_clear();
      t_same_cycle();
      t_bad_type();
      t_hpriv();
      t_ladder();
      t_soft();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule